// File: doc/BRIEF.md
# Escape-Tree Instruction Decoder

This block decodes one 16-bit instruction word per clock into a 7-bit instruction number, a set of per-operand and per-resource access flags, and the short immediates formed from the operand fields, both sign- and zero-extended to 32 bits. It sits between an instruction fetch stage and an execute stage. It does not fetch the trailing 32-bit constant word, hold registers or execute anything. It only reports what the word asks for and whether the word is legal.

Most instructions are named directly by a 6-bit major opcode. The all-ones major opcode does not name an instruction. It opens a nested space that is indexed first by operand field A. When A is all-ones, the space is indexed by operand field B. When B is also all-ones, it is indexed by operand field C. Words with the top bit set belong to an extension space. They are reported as non-native rather than illegal. Every result is registered, so the outputs describe the word that was presented one cycle earlier.

Top module: `idec_top`

## Requirements
- R1: While rst_ni is low, id_o reads 127 and every other output reads zero.
- R2: The word layout is: bit 15 = extension marker, bits 14:9 = major opcode, bits 8:6 = field A (op0), bits 5:3 = field B (op1), bits 2:0 = field C (op2). A native word with major opcode 0 to 44 gives id_o equal to that opcode, with illegal_o low.
- R3: With major opcode 63 and A = 7, B values 0, 1 and 2 give id_o 70, 71 and 73. With A = 7 and B = 7, C values 0, 1, 2, 5 and 6 give id_o 80, 81, 82, 83 and 84. Ids 81 to 84 (stack swap and over) raise no flags.
- R4: Flag vectors op_rd_o and op_wr_o carry bit 0 = A, bit 1 = B, bit 2 = C. Opcodes 33 to 44 (three-register arithmetic, logic and copies) write A and read B and C. Opcodes 25 to 32 (immediate arithmetic and shifts) write A and read B. Opcode 8 raises no flag.
- R5: Stores (15 to 18) read A and B and raise mem_wr_o. Loads (19 to 24) write A, read B and raise mem_rd_o. The library call (2) raises mem_rd_o, mem_wr_o, pc_rd_o and pc_wr_o.
- R6: The short jumps (0, 1) read A and raise pc_rd_o and pc_wr_o. Branches (9 to 14) read A and B and raise pc_rd_o and pc_wr_o. The indirect jump (73) reads C and raises pc_wr_o only. The long jump (80) raises pc_rd_o and pc_wr_o.
- R7: imm32_o is high for ids 70, 71 and 80 only. Ids 70 and 71 write C, and id 71 also raises pc_rd_o. Short constant loads 3 to 7 write A, and 3 and 4 also raise pc_rd_o.
- R8: Native words with major opcode 45 to 62 are illegal. So are words with major opcode 63 and A below 7, or A = 7 with B of 3 to 6, or A = B = 7 with C of 3, 4 or 7. For these, illegal_o is high, id_o is 127, and every access flag and imm32_o is low.
- R9: A word with bit 15 set gives ext_o high, illegal_o low, id_o 127 and every access flag low.
- R10: The immediates come from the low fields for every word: imm3 = C, imm6 = B*8 + C, imm9 = A*64 + B*8 + C. Each is given sign-extended (two's complement) and zero-extended to 32 bits.
- R11: Outputs change only on a rising clock edge and reflect the word present at that edge. A new word has no effect on the outputs before the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| instr_i | input | 16 | Instruction word |
| id_o | output | 7 | Instruction number, 127 when none |
| illegal_o | output | 1 | Native word with no assigned meaning |
| ext_o | output | 1 | Word belongs to the extension space |
| imm32_o | output | 1 | A 32-bit constant word follows |
| op_rd_o | output | 3 | Read enable per operand field (bit 0 = A) |
| op_wr_o | output | 3 | Write enable per operand field (bit 0 = A) |
| pc_rd_o | output | 1 | Instruction reads the program counter |
| pc_wr_o | output | 1 | Instruction writes the program counter |
| mem_rd_o | output | 1 | Instruction reads memory |
| mem_wr_o | output | 1 | Instruction writes memory |
| imm3_sx_o | output | 32 | Field C, sign-extended |
| imm3_zx_o | output | 32 | Field C, zero-extended |
| imm6_sx_o | output | 32 | B:C, sign-extended |
| imm6_zx_o | output | 32 | B:C, zero-extended |
| imm9_sx_o | output | 32 | A:B:C, sign-extended |
| imm9_zx_o | output | 32 | A:B:C, zero-extended |

## Verification
All 65,536 words are presented in turn, and each result is compared with a table-free model built from the requirements. The bench targets the edges of the escape tree. A decoder that descended on A below 7, or on B below 7, would give real ids to words that must be illegal. One that treated C = 3, 4 or 7 as stack operations would invent ids. The boundary opcodes 44/45 and 62/63 catch off-by-one range decoding. Words with bit 15 set catch a decoder that ignores the extension marker and decodes the low bits as native. The sign bit of each immediate width catches extension taken from the wrong bit. A check made one step before each edge catches a decoder that leaks the new word combinationally.

// File: rtl/idec_pkg.sv
package idec_pkg;

   localparam int ID_W = 7;

   localparam logic [ID_W-1:0] ID_NONE     = '1;
   localparam logic [ID_W-1:0] ID_LDC32    = 7'd70;
   localparam logic [ID_W-1:0] ID_LDPC32   = 7'd71;
   localparam logic [ID_W-1:0] ID_JIND     = 7'd73;
   localparam logic [ID_W-1:0] ID_JLONG    = 7'd80;
   localparam logic [ID_W-1:0] ID_SWAP_I   = 7'd81;
   localparam logic [ID_W-1:0] ID_SWAP_P   = 7'd82;
   localparam logic [ID_W-1:0] ID_OVER_I   = 7'd83;
   localparam logic [ID_W-1:0] ID_OVER_P   = 7'd84;

   // One decoded word: number, legality and resource use.
   typedef struct packed {
      logic [ID_W-1:0] id;
      logic            illegal;
      logic            imm32;
      logic [2:0]      op_rd;
      logic [2:0]      op_wr;
      logic            pc_rd;
      logic            pc_wr;
      logic            mem_rd;
      logic            mem_wr;
   } dec_t;

   localparam dec_t DEC_NONE = '{id: ID_NONE, default: '0};

endpackage

// File: rtl/idec_primary.sv
// Direct decode of the major opcodes that name one instruction each.
module idec_primary
   import idec_pkg::*;
#(
   parameter int OPC_W   = 6,
   parameter int LAST_OP = 44
) (
   input  logic [OPC_W-1:0] opc_i,
   output dec_t             dec_o
);

   always_comb begin
      dec_o = DEC_NONE;
      if (int'(opc_i) > LAST_OP) begin
         dec_o.illegal = 1'b1;
      end else begin
         dec_o.id = ID_W'(opc_i);
         case (opc_i) inside
            [0:1]: begin
               dec_o.op_rd = 3'b001;
               dec_o.pc_rd = 1'b1;
               dec_o.pc_wr = 1'b1;
            end
            2: begin
               dec_o.pc_rd  = 1'b1;
               dec_o.pc_wr  = 1'b1;
               dec_o.mem_rd = 1'b1;
               dec_o.mem_wr = 1'b1;
            end
            [3:4]: begin
               dec_o.op_wr = 3'b001;
               dec_o.pc_rd = 1'b1;
            end
            [5:7]: dec_o.op_wr = 3'b001;
            [9:14]: begin
               dec_o.op_rd = 3'b011;
               dec_o.pc_rd = 1'b1;
               dec_o.pc_wr = 1'b1;
            end
            [15:18]: begin
               dec_o.op_rd  = 3'b011;
               dec_o.mem_wr = 1'b1;
            end
            [19:24]: begin
               dec_o.op_wr  = 3'b001;
               dec_o.op_rd  = 3'b010;
               dec_o.mem_rd = 1'b1;
            end
            [25:32]: begin
               dec_o.op_wr = 3'b001;
               dec_o.op_rd = 3'b010;
            end
            [33:44]: begin
               dec_o.op_wr = 3'b001;
               dec_o.op_rd = 3'b110;
            end
            default: ;
         endcase
      end
   end

endmodule

// File: rtl/idec_escape.sv
// Nested decode under the all-ones major opcode: A, then B, then C.
module idec_escape
   import idec_pkg::*;
#(
   parameter int FLD_W = 3
) (
   input  logic [FLD_W-1:0] fa_i,
   input  logic [FLD_W-1:0] fb_i,
   input  logic [FLD_W-1:0] fc_i,
   output dec_t             dec_o
);

   localparam logic [FLD_W-1:0] ALL = '1;

   always_comb begin
      dec_o         = DEC_NONE;
      dec_o.illegal = 1'b1;
      if (fa_i == ALL) begin
         if (fb_i == ALL) begin
            dec_o.illegal = 1'b0;
            case (int'(fc_i))
               0: begin
                  dec_o.id    = ID_JLONG;
                  dec_o.imm32 = 1'b1;
                  dec_o.pc_rd = 1'b1;
                  dec_o.pc_wr = 1'b1;
               end
               1: dec_o.id = ID_SWAP_I;
               2: dec_o.id = ID_SWAP_P;
               5: dec_o.id = ID_OVER_I;
               6: dec_o.id = ID_OVER_P;
               default: dec_o.illegal = 1'b1;
            endcase
         end else begin
            dec_o.illegal = 1'b0;
            case (int'(fb_i))
               0: begin
                  dec_o.id    = ID_LDC32;
                  dec_o.imm32 = 1'b1;
                  dec_o.op_wr = 3'b100;
               end
               1: begin
                  dec_o.id    = ID_LDPC32;
                  dec_o.imm32 = 1'b1;
                  dec_o.op_wr = 3'b100;
                  dec_o.pc_rd = 1'b1;
               end
               2: begin
                  dec_o.id    = ID_JIND;
                  dec_o.op_rd = 3'b100;
                  dec_o.pc_wr = 1'b1;
               end
               default: dec_o.illegal = 1'b1;
            endcase
         end
      end
   end

endmodule

// File: rtl/idec_imm.sv
// Sign and zero extension of one concatenated operand immediate.
module idec_imm #(
   parameter int W     = 3,
   parameter int IMM_W = 32
) (
   input  logic [W-1:0]     raw_i,
   output logic [IMM_W-1:0] sx_o,
   output logic [IMM_W-1:0] zx_o
);

   localparam int PAD = IMM_W - W;

   assign sx_o = {{PAD{raw_i[W-1]}}, raw_i};
   assign zx_o = {{PAD{1'b0}}, raw_i};

endmodule

// File: rtl/idec_top.sv
module idec_top
   import idec_pkg::*;
#(
   parameter int INSTR_W = 16,
   parameter int OPC_W   = 6,
   parameter int FLD_W   = 3,
   parameter int IMM_W   = 32,
   parameter int LAST_OP = 44
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [15:0]      instr_i,
   output logic [6:0]       id_o,
   output logic             illegal_o,
   output logic             ext_o,
   output logic             imm32_o,
   output logic [2:0]       op_rd_o,
   output logic [2:0]       op_wr_o,
   output logic             pc_rd_o,
   output logic             pc_wr_o,
   output logic             mem_rd_o,
   output logic             mem_wr_o,
   output logic [31:0]      imm3_sx_o,
   output logic [31:0]      imm3_zx_o,
   output logic [31:0]      imm6_sx_o,
   output logic [31:0]      imm6_zx_o,
   output logic [31:0]      imm9_sx_o,
   output logic [31:0]      imm9_zx_o
);

   localparam int N_FLD  = 3;
   localparam int OPC_LO = N_FLD * FLD_W;
   localparam int MSB    = INSTR_W - 1;
   localparam logic [OPC_W-1:0] ESC = '1;

   // The decode map is tied to this word shape.
   if (INSTR_W != 1 + OPC_W + N_FLD * FLD_W) begin : g_bad_width
      $error("idec_top: INSTR_W must equal 1 + OPC_W + 3*FLD_W");
   end
   if (OPC_W != 6 || FLD_W != 3 || INSTR_W != 16 || IMM_W != 32) begin : g_bad_map
      $error("idec_top: opcode map needs 6-bit opcode, 3-bit fields, 32-bit immediates");
   end
   if (LAST_OP >= (1 << OPC_W) - 1) begin : g_bad_last
      $error("idec_top: LAST_OP collides with the escape opcode");
   end

   logic [OPC_W-1:0] opc;
   logic [FLD_W-1:0] fa, fb, fc;
   logic             ext_w;

   assign ext_w = instr_i[MSB];
   assign opc   = instr_i[OPC_LO +: OPC_W];
   assign fa    = instr_i[2*FLD_W +: FLD_W];
   assign fb    = instr_i[FLD_W +: FLD_W];
   assign fc    = instr_i[0 +: FLD_W];

   dec_t dec_pri, dec_esc, dec_sel, dec_q;

   idec_primary #(.OPC_W(OPC_W), .LAST_OP(LAST_OP)) u_pri (
      .opc_i (opc),
      .dec_o (dec_pri)
   );

   idec_escape #(.FLD_W(FLD_W)) u_esc (
      .fa_i  (fa),
      .fb_i  (fb),
      .fc_i  (fc),
      .dec_o (dec_esc)
   );

   always_comb begin
      if (ext_w)            dec_sel = DEC_NONE;
      else if (opc == ESC)  dec_sel = dec_esc;
      else                  dec_sel = dec_pri;
   end

   logic [IMM_W-1:0] sx_w [N_FLD];
   logic [IMM_W-1:0] zx_w [N_FLD];
   logic [IMM_W-1:0] sx_q [N_FLD];
   logic [IMM_W-1:0] zx_q [N_FLD];

   for (genvar k = 0; k < N_FLD; k++) begin : g_imm
      idec_imm #(.W((k + 1) * FLD_W), .IMM_W(IMM_W)) u_imm (
         .raw_i (instr_i[(k + 1) * FLD_W - 1 : 0]),
         .sx_o  (sx_w[k]),
         .zx_o  (zx_w[k])
      );
   end

   logic ext_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         dec_q <= DEC_NONE;
         ext_q <= 1'b0;
         for (int k = 0; k < N_FLD; k++) begin
            sx_q[k] <= '0;
            zx_q[k] <= '0;
         end
      end else begin
         dec_q <= dec_sel;
         ext_q <= ext_w;
         for (int k = 0; k < N_FLD; k++) begin
            sx_q[k] <= sx_w[k];
            zx_q[k] <= zx_w[k];
         end
      end
   end

   assign id_o      = dec_q.id;
   assign illegal_o = dec_q.illegal;
   assign ext_o     = ext_q;
   assign imm32_o   = dec_q.imm32;
   assign op_rd_o   = dec_q.op_rd;
   assign op_wr_o   = dec_q.op_wr;
   assign pc_rd_o   = dec_q.pc_rd;
   assign pc_wr_o   = dec_q.pc_wr;
   assign mem_rd_o  = dec_q.mem_rd;
   assign mem_wr_o  = dec_q.mem_wr;
   assign imm3_sx_o = sx_q[0];
   assign imm3_zx_o = zx_q[0];
   assign imm6_sx_o = sx_q[1];
   assign imm6_zx_o = zx_q[1];
   assign imm9_sx_o = sx_q[2];
   assign imm9_zx_o = zx_q[2];

endmodule

// File: rtl/idec_chk.sv
module idec_chk (
   input logic        clk_i,
   input logic        rst_ni,
   input logic [15:0] instr_i,
   input logic [6:0]  id_o,
   input logic        illegal_o,
   input logic        ext_o,
   input logic        imm32_o,
   input logic [2:0]  op_wr_o,
   input logic        pc_wr_o,
   input logic        mem_wr_o,
   input logic [31:0] imm9_sx_o,
   input logic [31:0] imm9_zx_o
);

   // R8: an illegal word requests no write of any kind
   p_illegal_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      illegal_o |-> (op_wr_o == 3'b000 && !pc_wr_o && !mem_wr_o && !imm32_o && id_o == 7'd127));

   // R9: extension words are never also illegal, and write nothing
   p_ext_excl_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ext_o |-> (!illegal_o && op_wr_o == 3'b000 && !pc_wr_o && !mem_wr_o));

   // R11: extension flag follows the marker bit one edge later
   p_latency_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ext_o == $past(instr_i[15]));

   // R7: the trailing-word flag belongs to three ids only
   p_imm32_ids_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      imm32_o |-> (id_o == 7'd70 || id_o == 7'd71 || id_o == 7'd80));

   // R3: ids from 70 upward come only from the escape opcode
   p_escape_src_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (id_o >= 7'd70 && id_o != 7'd127) |-> ($past(instr_i[14:9]) == 6'd63 && !$past(instr_i[15])));

   // R10: both extensions of imm9 agree on the low bits with the previous word
   p_imm9_bits_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (imm9_zx_o[8:0] == $past(instr_i[8:0])) && (imm9_sx_o[8:0] == imm9_zx_o[8:0]));

endmodule

bind idec_top idec_chk u_chk (
   .clk_i     (clk_i),
   .rst_ni    (rst_ni),
   .instr_i   (instr_i),
   .id_o      (id_o),
   .illegal_o (illegal_o),
   .ext_o     (ext_o),
   .imm32_o   (imm32_o),
   .op_wr_o   (op_wr_o),
   .pc_wr_o   (pc_wr_o),
   .mem_wr_o  (mem_wr_o),
   .imm9_sx_o (imm9_sx_o),
   .imm9_zx_o (imm9_zx_o)
);

// File: tb/test_idec_top.sv
module test_idec_top;

   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 200000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] instr = '0;

   logic [6:0]  id_o;
   logic        illegal_o, ext_o, imm32_o;
   logic [2:0]  op_rd_o, op_wr_o;
   logic        pc_rd_o, pc_wr_o, mem_rd_o, mem_wr_o;
   logic [31:0] imm3_sx_o, imm3_zx_o, imm6_sx_o, imm6_zx_o, imm9_sx_o, imm9_zx_o;

   always #(CLK_PERIOD / 2) clk = ~clk;

   idec_top i_idec_top (
      .clk_i     (clk),
      .rst_ni    (rst_n),
      .instr_i   (instr),
      .id_o      (id_o),
      .illegal_o (illegal_o),
      .ext_o     (ext_o),
      .imm32_o   (imm32_o),
      .op_rd_o   (op_rd_o),
      .op_wr_o   (op_wr_o),
      .pc_rd_o   (pc_rd_o),
      .pc_wr_o   (pc_wr_o),
      .mem_rd_o  (mem_rd_o),
      .mem_wr_o  (mem_wr_o),
      .imm3_sx_o (imm3_sx_o),
      .imm3_zx_o (imm3_zx_o),
      .imm6_sx_o (imm6_sx_o),
      .imm6_zx_o (imm6_zx_o),
      .imm9_sx_o (imm9_sx_o),
      .imm9_zx_o (imm9_zx_o)
   );

   int  n_checks = 0;
   int  n_errors = 0;
   bit  done = 1'b0;

   // Expected values for the current word
   logic       e_ext, e_ill, e_i32, e_pcr, e_pcw, e_mr, e_mw;
   logic [6:0] e_id;
   logic [2:0] e_rd, e_wr;

   task automatic chk(input string tag, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s %s: actual=%h expected=%h (word %h)", tag, what, act, exp, instr);
      end
   endtask

   task automatic model(input logic [15:0] w);
      int opc, a, b, c;
      opc = int'(w[14:9]);
      a = int'(w[8:6]);
      b = int'(w[5:3]);
      c = int'(w[2:0]);
      e_ext = w[15]; e_ill = 1'b0; e_id = 7'd127; e_i32 = 1'b0;
      e_rd = 3'b000; e_wr = 3'b000;
      e_pcr = 1'b0; e_pcw = 1'b0; e_mr = 1'b0; e_mw = 1'b0;
      if (e_ext) begin
      end else if (opc <= 44) begin
         e_id = 7'(opc);
         if (opc <= 1) begin e_rd = 3'b001; e_pcr = 1; e_pcw = 1; end
         else if (opc == 2) begin e_pcr = 1; e_pcw = 1; e_mr = 1; e_mw = 1; end
         else if (opc <= 4) begin e_wr = 3'b001; e_pcr = 1; end
         else if (opc <= 7) e_wr = 3'b001;
         else if (opc == 8) begin end
         else if (opc <= 14) begin e_rd = 3'b011; e_pcr = 1; e_pcw = 1; end
         else if (opc <= 18) begin e_rd = 3'b011; e_mw = 1; end
         else if (opc <= 24) begin e_wr = 3'b001; e_rd = 3'b010; e_mr = 1; end
         else if (opc <= 32) begin e_wr = 3'b001; e_rd = 3'b010; end
         else begin e_wr = 3'b001; e_rd = 3'b110; end
      end else if (opc == 63 && a == 7 && b == 7) begin
         if (c == 0) begin e_id = 7'd80; e_i32 = 1; e_pcr = 1; e_pcw = 1; end
         else if (c == 1) e_id = 7'd81;
         else if (c == 2) e_id = 7'd82;
         else if (c == 5) e_id = 7'd83;
         else if (c == 6) e_id = 7'd84;
         else e_ill = 1;
      end else if (opc == 63 && a == 7) begin
         if (b == 0) begin e_id = 7'd70; e_i32 = 1; e_wr = 3'b100; end
         else if (b == 1) begin e_id = 7'd71; e_i32 = 1; e_wr = 3'b100; e_pcr = 1; end
         else if (b == 2) begin e_id = 7'd73; e_rd = 3'b100; e_pcw = 1; end
         else e_ill = 1;
      end else begin
         e_ill = 1;
      end
   endtask

   function automatic logic [31:0] sext(input int v, input int bits);
      int s;
      s = v;
      if (v >= (1 << (bits - 1))) s = v - (1 << bits);
      return 32'(s);
   endfunction

   function automatic string id_tag(input logic [15:0] w);
      if (w[15]) return "R9";
      if (e_ill) return "R8";
      if (w[14:9] == 6'd63) return "R3";
      return "R2";
   endfunction

   function automatic string flag_tag(input logic [15:0] w);
      int opc;
      opc = int'(w[14:9]);
      if (w[15]) return "R9";
      if (e_ill) return "R8";
      if (opc == 63) return "R7";
      if (opc <= 1 || (opc >= 9 && opc <= 14)) return "R6";
      if (opc == 2 || (opc >= 15 && opc <= 24)) return "R5";
      if (opc >= 3 && opc <= 7) return "R7";
      return "R4";
   endfunction

   initial begin : watchdog
      repeat (WATCHDOG) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_errors++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end

   initial begin : main
      logic [6:0] prev_id;
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1", "id", 64'(id_o), 64'd127);
      chk("R1", "flags", 64'({illegal_o, ext_o, imm32_o, op_rd_o, op_wr_o,
                               pc_rd_o, pc_wr_o, mem_rd_o, mem_wr_o}), 64'd0);
      chk("R1", "imm", 64'({imm3_sx_o | imm3_zx_o | imm6_sx_o | imm6_zx_o,
                             imm9_sx_o | imm9_zx_o}), 64'd0);
      prev_id = 7'd127;
      rst_n = 1'b1;
      for (int w = 0; w < 65536; w++) begin
         instr = 16'(w);
         #1;
         // R11: no output moves before the edge
         chk("R11", "id before edge", 64'(id_o), 64'(prev_id));
         @(negedge clk);
         model(16'(w));
         chk(id_tag(instr), "ext/illegal/id", 64'({ext_o, illegal_o, id_o}),
             64'({e_ext, e_ill, e_id}));
         chk(flag_tag(instr), "flags",
             64'({imm32_o, op_rd_o, op_wr_o, pc_rd_o, pc_wr_o, mem_rd_o, mem_wr_o}),
             64'({e_i32, e_rd, e_wr, e_pcr, e_pcw, e_mr, e_mw}));
         // R10: immediates, all widths, both extensions
         chk("R10", "imm3", {imm3_sx_o, imm3_zx_o},
             {sext(w % 8, 3), 32'(w % 8)});
         chk("R10", "imm6", {imm6_sx_o, imm6_zx_o},
             {sext(w % 64, 6), 32'(w % 64)});
         chk("R10", "imm9", {imm9_sx_o, imm9_zx_o},
             {sext(w % 512, 9), 32'(w % 512)});
         prev_id = e_id;
      end
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

endmodule